// File: doc/BRIEF.md
# Lightweight Thread Interrupt Dispatcher

This block lets accelerator-side events reach a software thread without passing through the operating system's interrupt path. Each thread writes a table entry for every event source it wants to hear from. The entry holds the address of its handler routine and one argument word. Event packets arrive from the on-chip network and carry a thread number and a source number. Each packet is checked against the table when it arrives. A packet with a live entry is queued together with a copy of that entry. A packet with no live entry is discarded and counted.

Queued events are delivered one at a time in source priority order. Source 0 is an "accelerator ready" notification and ranks above source 1, a "wait-time" notification. Events of the same source keep their arrival order. The dispatcher presents the handler address, the argument, the thread and the source. The core jumps straight to the handler and saves no context. It then acknowledges, and the next event is released.

Top module: `uirq_top`

## Requirements
- R1: After reset, `intValid` is 0, `errCount` is 0 and `pktReady` is 1.
- R2: A packet accepted on clock edge T whose (thread, source) pair has a live entry is presented after edge T+1, provided nothing is being presented and no other event is queued. It is presented with that entry's handler and argument and with the packet's thread and source.
- R3: A packet accepted for a (thread, source) pair with no live entry produces no interrupt and raises `errCount` by exactly 1 on its acceptance edge.
- R4: When events of several sources are queued, the lowest source number is presented first: source 0 (accelerator ready) before source 1 (wait-time).
- R5: Events of the same source are presented in the order their packets were accepted.
- R6: A presented interrupt keeps all output fields unchanged until `intAck` is high on a clock edge. If another event is queued, it is presented right after that edge. Otherwise `intValid` falls.
- R7: While the queue for a source holds its full depth (4 per source by default), `pktReady` is 0 whenever `pktSrc` selects that source. A packet offered then is not taken. `pktReady` stays 1 for the other sources.
- R8: A table write (`regClear`=0) or deregistration (`regClear`=1) applies to packets accepted from the next clock edge onward. A packet accepted on the same edge as the write sees the old entry.
- R9: A queued event keeps the handler and argument captured when it was accepted, even if the entry is later rewritten.
- R10: `errCount` saturates at its maximum value (255 for the default 8-bit width) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Table write strobe |
| regClear | input | 1 | 1: deregister the entry, 0: register it |
| regThread | input | 2 | Thread number of the entry written |
| regSrc | input | 1 | Source number of the entry written |
| regHandler | input | 32 | Handler address to store |
| regArg | input | 32 | Argument word to store |
| pktValid | input | 1 | Event packet offered by the network |
| pktReady | output | 1 | Packet can be taken (queue of `pktSrc` not full) |
| pktThread | input | 2 | Target thread of the packet |
| pktSrc | input | 1 | Event source of the packet (0 ready, 1 wait-time) |
| intValid | output | 1 | An interrupt is being presented |
| intThread | output | 2 | Thread of the presented interrupt |
| intSrc | output | 1 | Source of the presented interrupt |
| intHandler | output | 32 | Handler address to jump to |
| intArg | output | 32 | Argument for the handler |
| intAck | input | 1 | Core has taken the presented interrupt |
| errCount | output | 8 | Saturating count of discarded packets |

## Verification
The bench targets the ordering corners. A wait-time event already queued must lose to a later ready event, and two threads on one source must come out in arrival order. A design with a reversed or round-robin arbiter, or with a queue read from the wrong end, shows the wrong handler after an acknowledge. It also holds the queue of one source full and offers one more packet. An overflowing design would deliver a fifth queued event, and a design that stalls every source would drop `pktReady` for the idle one. It sends a packet on the same edge as a registration and right after a deregistration. A design that reads the table with the wrong timing would deliver the first packet or the second instead of counting them. Finally it rewrites an entry while an event for that entry waits in the queue, to catch a design that reads the table at delivery. It also drives the error counter beyond its maximum, to catch a counter that wraps.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  parameter int unsigned THREAD_CNT = 4;
  parameter int unsigned SRC_CNT    = 2;
  parameter int unsigned ADDR_W     = 32;
  parameter int unsigned ARG_W      = 32;
  parameter int unsigned QDEPTH     = 4;
  parameter int unsigned ERR_W      = 8;

  localparam int unsigned THR_W   = (THREAD_CNT > 1) ? $clog2(THREAD_CNT) : 1;
  localparam int unsigned SRC_W   = (SRC_CNT > 1) ? $clog2(SRC_CNT) : 1;
  localparam int unsigned ENTRIES = THREAD_CNT * SRC_CNT;
  localparam int unsigned IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // One queued event: the thread plus the table contents captured on arrival.
  typedef struct packed {
    logic [THR_W-1:0]  thread;
    logic [ADDR_W-1:0] handler;
    logic [ARG_W-1:0]  arg;
  } qEntry_t;

  localparam int unsigned ENTRY_W = $bits(qEntry_t);

  // Strobes from control to datapath.
  typedef struct packed {
    logic [SRC_CNT-1:0] push;
    logic [SRC_CNT-1:0] pop;
    logic [SRC_W-1:0]   sel;
    logic               load;
    logic               clear;
    logic               errInc;
  } strobe_t;

  function automatic logic [IDX_W-1:0] tblIdx(input logic [THR_W-1:0] thr,
                                              input logic [SRC_W-1:0] src);
    return IDX_W'(thr) * IDX_W'(SRC_CNT) + IDX_W'(src);
  endfunction
endpackage

// File: rtl/uirq_fifo.sv
module uirq_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign dout  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
  import uirq_pkg::*;
(
  input  logic               pktValid,
  input  logic [SRC_W-1:0]   pktSrc,
  input  logic               tblHit,
  input  logic [SRC_CNT-1:0] emptyVec,
  input  logic [SRC_CNT-1:0] fullVec,
  input  logic               intValid,
  input  logic               intAck,
  output logic               pktReady,
  output strobe_t            strobe
);
  logic srcOk;
  logic accept;
  logic anyPending;
  logic outFree;
  logic [SRC_W-1:0] pick;

  assign srcOk    = (int'(pktSrc) < int'(SRC_CNT));
  assign pktReady = !srcOk || !fullVec[pktSrc];
  assign accept   = pktValid && pktReady;
  assign outFree  = !intValid || intAck;

  // Lowest source number wins.
  always_comb begin
    pick       = '0;
    anyPending = 1'b0;
    for (int s = int'(SRC_CNT) - 1; s >= 0; s--) begin
      if (!emptyVec[s]) begin
        pick       = SRC_W'(s);
        anyPending = 1'b1;
      end
    end
  end

  always_comb begin
    strobe        = '0;
    strobe.sel    = pick;
    strobe.errInc = accept && !(srcOk && tblHit);
    if (accept && srcOk && tblHit) strobe.push[pktSrc] = 1'b1;
    if (outFree && anyPending) begin
      strobe.pop[pick] = 1'b1;
      strobe.load      = 1'b1;
    end
    strobe.clear = intValid && intAck && !anyPending;
  end
endmodule

// File: rtl/uirq_datapath.sv
module uirq_datapath
  import uirq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regClear,
  input  logic [THR_W-1:0]   regThread,
  input  logic [SRC_W-1:0]   regSrc,
  input  logic [ADDR_W-1:0]  regHandler,
  input  logic [ARG_W-1:0]   regArg,
  input  logic [THR_W-1:0]   pktThread,
  input  logic [SRC_W-1:0]   pktSrc,
  input  strobe_t            strobe,
  output logic               tblHit,
  output logic [SRC_CNT-1:0] emptyVec,
  output logic [SRC_CNT-1:0] fullVec,
  output logic               intValid,
  output logic [THR_W-1:0]   intThread,
  output logic [SRC_W-1:0]   intSrc,
  output logic [ADDR_W-1:0]  intHandler,
  output logic [ARG_W-1:0]   intArg,
  output logic [ERR_W-1:0]   errCount
);
  // Registration table, one entry per (thread, source).
  logic              tblValid   [ENTRIES];
  logic [ADDR_W-1:0] tblHandler [ENTRIES];
  logic [ARG_W-1:0]  tblArg     [ENTRIES];

  logic [IDX_W-1:0] wrIdx, rdIdx;
  logic             wrOk, rdOk;

  assign wrIdx = tblIdx(regThread, regSrc);
  assign rdIdx = tblIdx(pktThread, pktSrc);
  assign wrOk  = (int'(regSrc) < int'(SRC_CNT)) && (int'(wrIdx) < int'(ENTRIES));
  assign rdOk  = (int'(pktSrc) < int'(SRC_CNT)) && (int'(rdIdx) < int'(ENTRIES));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < int'(ENTRIES); e++) tblValid[e] <= 1'b0;
    end else if (regWrEn && wrOk) begin
      tblValid[wrIdx] <= !regClear;
    end
  end

  always_ff @(posedge clk) begin
    if (regWrEn && wrOk && !regClear) begin
      tblHandler[wrIdx] <= regHandler;
      tblArg[wrIdx]     <= regArg;
    end
  end

  qEntry_t pushEntry;
  assign tblHit = rdOk && tblValid[rdIdx];

  always_comb begin
    pushEntry.thread  = pktThread;
    pushEntry.handler = rdOk ? tblHandler[rdIdx] : '0;
    pushEntry.arg     = rdOk ? tblArg[rdIdx] : '0;
  end

  // One queue per source.
  qEntry_t headEntry [SRC_CNT];

  for (genvar s = 0; s < int'(SRC_CNT); s++) begin : g_queue
    logic [ENTRY_W-1:0] headBits;
    uirq_fifo #(.WIDTH(ENTRY_W), .DEPTH(QDEPTH)) queue_i (
      .clk   (clk),
      .rstN  (rstN),
      .push  (strobe.push[s]),
      .pop   (strobe.pop[s]),
      .din   (pushEntry),
      .dout  (headBits),
      .empty (emptyVec[s]),
      .full  (fullVec[s])
    );
    assign headEntry[s] = qEntry_t'(headBits);
  end

  qEntry_t selEntry;
  assign selEntry = headEntry[strobe.sel];

  // Presentation register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intValid   <= 1'b0;
      intThread  <= '0;
      intSrc     <= '0;
      intHandler <= '0;
      intArg     <= '0;
    end else if (strobe.load) begin
      intValid   <= 1'b1;
      intThread  <= selEntry.thread;
      intSrc     <= strobe.sel;
      intHandler <= selEntry.handler;
      intArg     <= selEntry.arg;
    end else if (strobe.clear) begin
      intValid   <= 1'b0;
    end
  end

  // Discard counter, saturating.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             errCount <= '0;
    else if (strobe.errInc && !(&errCount)) errCount <= errCount + 1'b1;
  end
endmodule

// File: rtl/uirq_top.sv
module uirq_top
  import uirq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regClear,
  input  logic [THR_W-1:0]   regThread,
  input  logic [SRC_W-1:0]   regSrc,
  input  logic [ADDR_W-1:0]  regHandler,
  input  logic [ARG_W-1:0]   regArg,
  input  logic               pktValid,
  output logic               pktReady,
  input  logic [THR_W-1:0]   pktThread,
  input  logic [SRC_W-1:0]   pktSrc,
  output logic               intValid,
  output logic [THR_W-1:0]   intThread,
  output logic [SRC_W-1:0]   intSrc,
  output logic [ADDR_W-1:0]  intHandler,
  output logic [ARG_W-1:0]   intArg,
  input  logic               intAck,
  output logic [ERR_W-1:0]   errCount
);
  strobe_t            strobe;
  logic               tblHit;
  logic [SRC_CNT-1:0] emptyVec, fullVec;
  logic [SRC_CNT-1:0] pushVec, popVec;

  assign pushVec = strobe.push;
  assign popVec  = strobe.pop;

  uirq_ctrl ctrl_i (
    .pktValid (pktValid),
    .pktSrc   (pktSrc),
    .tblHit   (tblHit),
    .emptyVec (emptyVec),
    .fullVec  (fullVec),
    .intValid (intValid),
    .intAck   (intAck),
    .pktReady (pktReady),
    .strobe   (strobe)
  );

  uirq_datapath dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regClear   (regClear),
    .regThread  (regThread),
    .regSrc     (regSrc),
    .regHandler (regHandler),
    .regArg     (regArg),
    .pktThread  (pktThread),
    .pktSrc     (pktSrc),
    .strobe     (strobe),
    .tblHit     (tblHit),
    .emptyVec   (emptyVec),
    .fullVec    (fullVec),
    .intValid   (intValid),
    .intThread  (intThread),
    .intSrc     (intSrc),
    .intHandler (intHandler),
    .intArg     (intArg),
    .errCount   (errCount)
  );
endmodule

// File: rtl/uirq_checker.sv
module uirq_checker
  import uirq_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               intValid,
  input logic               intAck,
  input logic [THR_W-1:0]   intThread,
  input logic [ADDR_W-1:0]  intHandler,
  input logic [ARG_W-1:0]   intArg,
  input logic [ERR_W-1:0]   errCount,
  input logic [SRC_CNT-1:0] pushVec,
  input logic [SRC_CNT-1:0] popVec,
  input logic [SRC_CNT-1:0] emptyVec,
  input logic [SRC_CNT-1:0] fullVec
);
  assert_reset_R1: assert property (@(posedge clk)
    !rstN |=> (!intValid && errCount == '0));

  assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (!rstN)
    (intValid && !intAck) |=> (intValid && $stable(intHandler) && $stable(intArg)
                               && $stable(intThread)));

  assert_err_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (errCount == $past(errCount)) || (errCount == $past(errCount) + 1'b1));

  assert_single_pop_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(popVec));

  for (genvar s = 0; s < int'(SRC_CNT); s++) begin : g_src
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
      pushVec[s] |-> !fullVec[s]);
    assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (!rstN)
      popVec[s] |-> !emptyVec[s]);
    if (s > 0) begin : g_prio
      assert_priority_R4: assert property (@(posedge clk) disable iff (!rstN)
        popVec[s] |-> (&emptyVec[s-1:0]));
    end
  end
endmodule

bind uirq_top uirq_checker chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .intValid   (intValid),
  .intAck     (intAck),
  .intThread  (intThread),
  .intHandler (intHandler),
  .intArg     (intArg),
  .errCount   (errCount),
  .pushVec    (pushVec),
  .popVec     (popVec),
  .emptyVec   (emptyVec),
  .fullVec    (fullVec)
);

// File: tb/uirq_top_tb_top.sv
module uirq_top_tb_top;
  import uirq_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regClear = 1'b0;
  logic [THR_W-1:0]  regThread = '0;
  logic [SRC_W-1:0]  regSrc = '0;
  logic [ADDR_W-1:0] regHandler = '0;
  logic [ARG_W-1:0]  regArg = '0;
  logic pktValid = 1'b0;
  logic pktReady;
  logic [THR_W-1:0] pktThread = '0;
  logic [SRC_W-1:0] pktSrc = '0;
  logic intValid;
  logic [THR_W-1:0]  intThread;
  logic [SRC_W-1:0]  intSrc;
  logic [ADDR_W-1:0] intHandler;
  logic [ARG_W-1:0]  intArg;
  logic intAck = 1'b0;
  logic [ERR_W-1:0] errCount;

  int checks = 0;
  int failures = 0;
  int expErr = 0;
  bit done = 1'b0;
  localparam int ERR_MAX = (1 << ERR_W) - 1;

  always #5 clk = ~clk;

  uirq_top dut_i (.*);

  task automatic checkVal(input string req, input string what,
                          input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic regWrite(input int thr, input int src, input longint h,
                          input longint a, input bit clr);
    regWrEn = 1'b1; regClear = clr;
    regThread = THR_W'(thr); regSrc = SRC_W'(src);
    regHandler = ADDR_W'(h); regArg = ARG_W'(a);
    step();
    regWrEn = 1'b0; regClear = 1'b0;
  endtask

  task automatic sendPkt(input int thr, input int src);
    pktValid = 1'b1; pktThread = THR_W'(thr); pktSrc = SRC_W'(src);
    step();
    pktValid = 1'b0;
  endtask

  task automatic ackInt();
    intAck = 1'b1;
    step();
    intAck = 1'b0;
  endtask

  task automatic expectInt(input string req, input int thr, input int src,
                           input longint h, input longint a);
    checkVal(req, "intValid", intValid, 1);
    checkVal(req, "intThread", intThread, thr);
    checkVal(req, "intSrc", intSrc, src);
    checkVal(req, "intHandler", intHandler, h);
    checkVal(req, "intArg", intArg, a);
  endtask

  task automatic t_reset();
    checkVal("R1", "intValid", intValid, 0);
    checkVal("R1", "errCount", errCount, 0);
    checkVal("R1", "pktReady", pktReady, 1);
  endtask

  task automatic t_basic();
    regWrite(1, 0, 'h1000, 'hA1, 0);
    sendPkt(1, 0);
    checkVal("R2", "intValid one edge after accept", intValid, 0);
    step();
    expectInt("R2", 1, 0, 'h1000, 'hA1);
    ackInt();
    checkVal("R6", "intValid after last ack", intValid, 0);
  endtask

  task automatic t_drop();
    sendPkt(2, 1);
    expErr++;
    checkVal("R3", "errCount after drop", errCount, expErr);
    step();
    checkVal("R3", "no interrupt for dropped", intValid, 0);
  endtask

  task automatic t_fifo_hold();
    regWrite(2, 1, 'h2000, 'hB2, 0);
    regWrite(3, 1, 'h3000, 'hB3, 0);
    sendPkt(2, 1);
    sendPkt(3, 1);
    expectInt("R5", 2, 1, 'h2000, 'hB2);
    for (int i = 0; i < 3; i++) begin
      step();
      expectInt("R6", 2, 1, 'h2000, 'hB2);
    end
    ackInt();
    expectInt("R5", 3, 1, 'h3000, 'hB3);
    ackInt();
    checkVal("R6", "intValid drained", intValid, 0);
  endtask

  task automatic t_priority();
    regWrite(0, 1, 'h4000, 'hC1, 0);
    regWrite(0, 0, 'h5000, 'hC0, 0);
    sendPkt(0, 1);
    step();
    expectInt("R4", 0, 1, 'h4000, 'hC1);
    sendPkt(0, 1);
    sendPkt(0, 0);
    ackInt();
    expectInt("R4", 0, 0, 'h5000, 'hC0);
    ackInt();
    expectInt("R4", 0, 1, 'h4000, 'hC1);
    ackInt();
    checkVal("R4", "intValid drained", intValid, 0);
  endtask

  task automatic t_full();
    sendPkt(2, 1);
    step();
    for (int i = 0; i < int'(QDEPTH); i++) sendPkt(2, 1);
    pktSrc = SRC_W'(1);
    #1 checkVal("R7", "pktReady full source", pktReady, 0);
    pktSrc = SRC_W'(0);
    #1 checkVal("R7", "pktReady other source", pktReady, 1);
    pktThread = THR_W'(3); pktSrc = SRC_W'(1); pktValid = 1'b1;
    step();
    step();
    pktValid = 1'b0;
    checkVal("R7", "errCount unchanged", errCount, expErr);
    for (int i = 0; i <= int'(QDEPTH); i++) begin
      checkVal("R7", "drain valid", intValid, 1);
      checkVal("R7", "drain handler", intHandler, 'h2000);
      ackInt();
    end
    checkVal("R7", "no extra entry", intValid, 0);
  endtask

  task automatic t_reg_timing();
    regWrEn = 1'b1; regThread = THR_W'(1); regSrc = SRC_W'(1);
    regHandler = 'h8000; regArg = 'hD1;
    pktValid = 1'b1; pktThread = THR_W'(1); pktSrc = SRC_W'(1);
    step();
    regWrEn = 1'b0; pktValid = 1'b0;
    expErr++;
    checkVal("R8", "same-edge packet dropped", errCount, expErr);
    step();
    checkVal("R8", "same-edge no interrupt", intValid, 0);
    sendPkt(1, 1);
    step();
    expectInt("R8", 1, 1, 'h8000, 'hD1);
    ackInt();
    regWrite(1, 1, 0, 0, 1);
    sendPkt(1, 1);
    expErr++;
    checkVal("R8", "after deregister dropped", errCount, expErr);
    step();
    checkVal("R8", "after deregister no interrupt", intValid, 0);
  endtask

  task automatic t_captured();
    regWrite(3, 0, 'h6000, 'hE0, 0);
    sendPkt(3, 0);
    step();
    expectInt("R9", 3, 0, 'h6000, 'hE0);
    sendPkt(3, 0);
    regWrite(3, 0, 'h7000, 'hE7, 0);
    ackInt();
    expectInt("R9", 3, 0, 'h6000, 'hE0);
    ackInt();
    sendPkt(3, 0);
    step();
    expectInt("R9", 3, 0, 'h7000, 'hE7);
    ackInt();
  endtask

  task automatic t_saturate();
    while (expErr < ERR_MAX + 3) begin
      sendPkt(2, 0);
      expErr++;
    end
    checkVal("R10", "errCount saturated", errCount, ERR_MAX);
    checkVal("R10", "no interrupt", intValid, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step();
    step();
    rstN = 1'b1;
    step();
    t_reset();
    t_basic();
    t_drop();
    t_fifo_hold();
    t_priority();
    t_full();
    t_reg_timing();
    t_captured();
    t_saturate();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule